// File: doc/BRIEF.md
# Serial Result Output Port for a Sampling Converter

This block takes each finished conversion word from a converter's sequencer and sends it out one bit at a time on a serial data line, most significant bit first, inside an active-low framing strobe. A single start strobe hands the block a result word. A coding input, sampled with that strobe, picks one of two output formats. Straight binary sends the word unchanged. Two's complement inverts the top bit of the offset-binary result, for bipolar use.

Two clocking modes are supported, and the mode is sampled when a frame starts. In internal mode the block makes its own serial clock from the system clock, with fixed two-cycle low and high phases. The framing strobe leads the first rising edge by two cycles and trails the last rising edge by two cycles. In external mode a receiver supplies the serial clock. The block synchronizes that clock and presents each new bit after a falling edge. If a result arrives while a frame is still being shifted, the block holds it and sends it once the current frame has finished.

Top module: `adc_serial_port`

## Requirements
- R1: In internal mode the serial clock output is low whenever the frame strobe is high. During a frame it is high for exactly 2 clock cycles at each pulse, and each low stretch between two rising edges is also exactly 2 cycles. In external mode the serial clock output stays low.
- R2: Each frame carries exactly 16 bits, most significant first. In internal mode the data line changes only when the serial clock falls. It has held its value for the 2 cycles before each rising edge and keeps it for the cycle that follows.
- R3: In internal mode the frame strobe goes low 2 cycles before the first rising serial-clock edge. It goes high again 2 cycles after the 16th rising edge.
- R4: In internal mode, with the port idle, the frame strobe is low from the first clock edge after the edge that samples the start strobe. The first falling serial-clock edge comes 5 cycles after the sampling edge.
- R5: With coding input 0 (binary), the transmitted word equals the input word. A saturated input of all ones (0xFFFF) is sent as all ones, and all zeros (0x0000) is sent as all zeros.
- R6: With coding input 1 (two's complement), bit 15 of the word is inverted and bits 14..0 pass unchanged, so 0xFFFF is sent as 0x7FFF and 0x0000 as 0x8000. The coding is sampled together with the start strobe.
- R7: A start strobe that arrives during a frame is held. Its word goes out in the next frame, after the frame strobe has been high for at least one cycle, and in order.
- R8: In external mode the block presents the next bit after each synchronized falling edge of the external serial clock. The frame ends on the falling edge that follows the 16th rising edge.
- R9: In external mode, if the external serial clock is low when a result is pending, the frame strobe falls at once and the most significant bit is driven. If the clock is high, both wait for its next falling edge.
- R10: While reset is asserted, the frame strobe is high and the serial clock and data outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | One-cycle pulse: resultWord is valid |
| resultWord | input | 16 | Offset-binary conversion result |
| twosComp | input | 1 | Coding select: 0 binary, 1 two's complement |
| extMode | input | 1 | Clock mode: 0 internal, 1 external |
| sclkIn | input | 1 | External serial clock, asynchronous |
| sclkOut | output | 1 | Internally generated serial clock |
| sdata | output | 1 | Serial data, most significant bit first |
| frameN | output | 1 | Active-low framing strobe |

## Verification
The assertions check the internal-mode waveform on every cycle: the clock is quiet outside a frame and its high pulses last two cycles, the data is stable around each rising edge, and the clock is low when the frame opens. Only the bench scenarios can show the rest. These are the word contents and bit order under both codings and at saturation, the exact lead and trail counts, the queuing of a result that arrives during a frame, and the external-clock cases where the clock is low or high when a result is ready.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_INT  = 2'd2,
    ST_EXT  = 2'd3
  } spState_e;

  typedef struct packed {
    logic loadWord;
    logic shiftBit;
  } dpCtrl_t;

endpackage

// File: rtl/adc_sp_datapath.sv
module adc_sp_datapath
  import adc_sp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [WORD_W-1:0] resultWord,
  input  logic              twosComp,
  input  dpCtrl_t           ctrl,
  output logic              pendValid,
  output logic              msbOut
);

  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] codedWord;
  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] shiftReg;

  // offset binary to two's complement: flip the sign position only
  always_comb begin
    codedWord = resultWord;
    if (twosComp) codedWord[MSB] = ~resultWord[MSB];
  end

  // one-deep holding stage so a result can wait for the running frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      pendValid <= 1'b0;
    end else if (startStb) begin
      holdReg   <= codedWord;
      pendValid <= 1'b1;
    end else if (ctrl.loadWord) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctrl.loadWord) begin
      shiftReg <= holdReg;
    end else if (ctrl.shiftBit) begin
      shiftReg <= {shiftReg[MSB-1:0], 1'b0};
    end
  end

  assign msbOut = shiftReg[MSB];

endmodule

// File: rtl/adc_sp_control.sv
module adc_sp_control
  import adc_sp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pendValid,
  input  logic    extMode,
  input  logic    sclkIn,
  output dpCtrl_t ctrl,
  output logic    sclkOut,
  output logic    frameActive
);

  localparam int PH_COUNT = WORD_W * 4;
  localparam int PH_W     = $clog2(PH_COUNT);
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PH_COUNT - 1);
  localparam logic [CNT_W-1:0] BITS_ALL = CNT_W'(WORD_W);

  spState_e         state, stateNxt;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] riseCnt;

  // external clock synchronizer, depth chosen by parameter
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sclkLvl;
  logic                   sclkPrev;
  logic                   riseEdge;
  logic                   fallEdge;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= sclkIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclkIn};
      end
    end
  endgenerate

  assign sclkLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkLvl;
  end

  assign riseEdge = sclkLvl & ~sclkPrev;
  assign fallEdge = ~sclkLvl & sclkPrev;

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    unique case (state)
      ST_IDLE: begin
        if (pendValid) begin
          if (!extMode) begin
            ctrl.loadWord = 1'b1;
            stateNxt      = ST_INT;
          end else if (!sclkLvl) begin
            ctrl.loadWord = 1'b1;
            stateNxt      = ST_EXT;
          end else begin
            stateNxt = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (fallEdge) begin
          ctrl.loadWord = 1'b1;
          stateNxt      = ST_EXT;
        end
      end
      ST_INT: begin
        if (phase == PH_LAST) begin
          stateNxt = ST_IDLE;
        end else if (phase[1:0] == 2'b11) begin
          ctrl.shiftBit = 1'b1;
        end
      end
      ST_EXT: begin
        if (fallEdge && riseCnt == BITS_ALL) begin
          stateNxt = ST_IDLE;
        end else if (fallEdge && riseCnt != '0) begin
          ctrl.shiftBit = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (state == ST_INT && phase != PH_LAST) begin
      phase <= phase + 1'b1;
    end else begin
      phase <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseCnt <= '0;
    end else if (ctrl.loadWord) begin
      riseCnt <= '0;
    end else if (state == ST_EXT && riseEdge && riseCnt != BITS_ALL) begin
      riseCnt <= riseCnt + 1'b1;
    end
  end

  assign sclkOut     = (state == ST_INT) & phase[1];
  assign frameActive = (state == ST_INT) | (state == ST_EXT);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [WORD_W-1:0] resultWord,
  input  logic              twosComp,
  input  logic              extMode,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sdata,
  output logic              frameN
);

  dpCtrl_t ctrl;
  logic    pendValid;
  logic    msbOut;
  logic    frameActive;

  adc_sp_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .startStb   (startStb),
    .resultWord (resultWord),
    .twosComp   (twosComp),
    .ctrl       (ctrl),
    .pendValid  (pendValid),
    .msbOut     (msbOut)
  );

  adc_sp_control #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .pendValid   (pendValid),
    .extMode     (extMode),
    .sclkIn      (sclkIn),
    .ctrl        (ctrl),
    .sclkOut     (sclkOut),
    .frameActive (frameActive)
  );

  assign sdata  = frameActive & msbOut;
  assign frameN = ~frameActive;

endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker (
  input logic clk,
  input logic rstN,
  input logic sclkOut,
  input logic sdata,
  input logic frameN
);

  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    frameN |-> !sclkOut) else $error("AST_SCLK_QUIET"); // R1

  AST_SCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |=> sclkOut ##1 !sclkOut) else $error("AST_SCLK_HIGH_TWO"); // R1

  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |-> ($stable(sdata) && sdata == $past(sdata, 2))) else $error("AST_DATA_SETUP"); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |=> $stable(sdata)) else $error("AST_DATA_HOLD"); // R2

  AST_FRAME_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN) |-> !sclkOut ##1 !sclkOut) else $error("AST_FRAME_LEAD"); // R3

endmodule

bind adc_serial_port adc_sp_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclkOut (sclkOut),
  .sdata   (sdata),
  .frameN  (frameN)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startStb;
  logic [15:0] resultWord;
  logic        twosComp;
  logic        extMode;
  logic        sclkIn;
  logic        sclkOut;
  logic        sdata;
  logic        frameN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  bit extRun  = 1'b0;
  int divCnt  = 0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  adc_serial_port dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .resultWord(resultWord),
    .twosComp(twosComp), .extMode(extMode), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .sdata(sdata), .frameN(frameN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // external serial clock: 8 cycles low, 8 high, driven at the active edge
  always @(posedge clk) begin
    if (!extRun) begin
      sclkIn <= 1'b0;
      divCnt <= 0;
    end else if (divCnt == 7) begin
      sclkIn <= ~sclkIn;
      divCnt <= 0;
    end else begin
      divCnt <= divCnt + 1;
    end
  end

  // monitor / scoreboard
  int          cyc = 0;
  logic        prevFrameN = 1'b1;
  logic        prevLine = 1'b0;
  logic        prevSdata = 1'b0;
  logic [15:0] shiftIn;
  int          bitsSeen;
  int          frameFallCyc;
  int          lastRiseCyc;
  int          lastFallCyc;

  always @(negedge clk) begin
    logic line;
    cyc++;
    line = extMode ? sclkIn : sclkOut;
    if (rstN) begin
      if (prevFrameN && !frameN) begin
        frameFallCyc = cyc;
        bitsSeen     = 0;
        shiftIn      = '0;
      end
      if (!frameN && line && !prevLine) begin
        if (!extMode) begin
          if (bitsSeen == 0) chk(cyc - frameFallCyc == 2, "R3 lead", cyc - frameFallCyc, 2);
          else               chk(cyc - lastFallCyc == 2, "R1 low phase", cyc - lastFallCyc, 2);
        end else begin
          chk(sclkOut == 1'b0, "R1 ext clock quiet", sclkOut, 0);
        end
        shiftIn     = {shiftIn[14:0], sdata};
        bitsSeen    = bitsSeen + 1;
        lastRiseCyc = cyc;
      end
      if (!frameN && !extMode && !line && prevLine) begin
        chk(cyc - lastRiseCyc == 2, "R1 high phase", cyc - lastRiseCyc, 2);
        lastFallCyc = cyc;
      end
      if (!frameN && !prevFrameN && !extMode && sdata != prevSdata)
        chk(!sclkOut && prevLine, "R2 data edge", sclkOut, 0);
      if (!prevFrameN && frameN) begin
        chk(bitsSeen == 16, "R2 bit count", bitsSeen, 16);
        if (!extMode) chk(cyc - lastRiseCyc == 2, "R3 trail", cyc - lastRiseCyc, 2);
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", shiftIn, 0);
        end else begin
          logic [15:0] e;
          string       t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(shiftIn == e, t, shiftIn, e);
        end
      end
    end
    prevFrameN = frameN;
    prevLine   = line;
    prevSdata  = sdata;
  end

  function automatic logic [15:0] coded(input logic [15:0] w, input logic tc);
    return tc ? {~w[15], w[14:0]} : w;
  endfunction

  task automatic sendWord(input logic [15:0] w, input logic tc, input string tag);
    @(negedge clk);
    resultWord = w;
    twosComp   = tc;
    startStb   = 1'b1;
    expQ.push_back(coded(w, tc));
    tagQ.push_back(tag);
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; startStb = 1'b0; resultWord = '0; twosComp = 1'b0; extMode = 1'b0;
    repeat (3) @(negedge clk);
    chk(frameN == 1'b1, "R10 frame idle", frameN, 1);
    chk(sclkOut == 1'b0, "R10 sclk idle", sclkOut, 0);
    chk(sdata == 1'b0, "R10 data idle", sdata, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4: lead timing from the start strobe, internal mode
    sendWord(16'hA5C3, 1'b0, "R5 binary word");
    chk(frameN == 1'b1, "R4 frame before", frameN, 1);
    @(negedge clk);
    chk(frameN == 1'b0, "R4 frame fall", frameN, 0);
    chk(sdata == 1'b1, "R4 msb driven", sdata, 1);
    repeat (3) @(negedge clk);
    chk(sclkOut == 1'b1, "R4 sclk high", sclkOut, 1);
    @(negedge clk);
    chk(sclkOut == 1'b0, "R4 first fall", sclkOut, 0);
    drain();

    sendWord(16'h1234, 1'b0, "R5 binary pattern");
    drain();
    sendWord(16'hFFFF, 1'b0, "R5 saturated high");
    drain();
    sendWord(16'h0000, 1'b0, "R5 saturated low");
    drain();
    sendWord(16'hFFFF, 1'b1, "R6 twos high");
    drain();
    sendWord(16'h0000, 1'b1, "R6 twos low");
    drain();
    sendWord(16'h8001, 1'b1, "R6 twos mid");
    drain();

    // R7: second result during a frame
    sendWord(16'h5A5A, 1'b0, "R7 first word");
    repeat (10) @(negedge clk);
    sendWord(16'h0F0F, 1'b1, "R7 queued word");
    drain();
    chk(expQ.size() == 0, "R7 both sent", expQ.size(), 0);

    // external mode
    extMode = 1'b1;
    extRun  = 1'b1;
    // R9 low case: start just after the clock fell
    while (sclkIn !== 1'b1) @(negedge clk);
    while (sclkIn !== 1'b0) @(negedge clk);
    sendWord(16'hC0DE, 1'b0, "R8 ext word");
    @(negedge clk);
    chk(frameN == 1'b0, "R9 low start", frameN, 0);
    chk(sdata == 1'b1, "R9 msb at once", sdata, 1);
    drain();

    // R9 high case: start while the clock is high
    while (sclkIn !== 1'b0) @(negedge clk);
    while (sclkIn !== 1'b1) @(negedge clk);
    sendWord(16'h3C71, 1'b1, "R8 ext twos");
    @(negedge clk);
    chk(frameN == 1'b1, "R9 waits high", frameN, 1);
    repeat (2) @(negedge clk);
    chk(frameN == 1'b1, "R9 still waiting", frameN, 1);
    while (sclkIn !== 1'b0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(frameN == 1'b0, "R9 start after fall", frameN, 0);
    chk(sdata == 1'b1, "R9 msb after fall", sdata, 1);
    drain();

    extRun = 1'b0;
    done   = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule